// File: doc/BRIEF.md
# Stop-Grant Power-State Sequencer

This controller moves a processor core from normal execution into a clock-gated low-power state and back again. System logic requests the stop with an active-low level, `stop_req_n`, which may be asynchronous to the core clock. The sequencer synchronizes that level and waits for the core to report an instruction-retirement boundary. It then works through an ordered handshake. First it asks the pipeline to flush and waits for the flush to complete. Next it waits until the bus unit reports no outstanding cycles. It then requests a stop-grant acknowledge bus cycle and holds that request until bus ready returns. Only after that does it drop the core clock enable.

Before the clock is gated, a write-buffer-empty indication must also have been seen, unless its qualifier enable is cleared. The bus-ready and write-buffer qualifiers may arrive in either order or in the same cycle. While the core sits in stop grant, system logic may halt the clock entirely. When the clock restarts, the controller is still in stop grant. When the request is withdrawn, the sequencer first re-enables the core clock. One cycle later it pulses `resume`.

Top module: `stopgnt_seq`

## Requirements
- R1: While reset is applied, and for the two clock edges that it takes to release internally, `pwr_state` is 0 (running), `core_clk_en` is 1, and `flush_req`, `sg_cyc_req` and `resume` are 0.
- R2: `stop_req_n` passes through a two-flop synchronizer. A low level first sampled at edge k moves the machine from running (0) to waiting for a boundary (1) at edge k+2. A low pulse that lasts two clocks is therefore always caught.
- R3: In the boundary-wait state (1), the machine stays put until `retire_bnd` is sampled high with the request still present. It then enters the flush state (2).
- R4: If the synchronized request goes away in the boundary-wait state, the machine returns to running (0) without ever raising `flush_req`.
- R5: The ordering is strict. `flush_req` is high in the flush state (2) until `flush_done` is sampled high. The drain state (3) then lasts until `bus_idle` is sampled high, after which the machine enters the acknowledge state (4).
- R6: `sg_cyc_req` is high for the whole acknowledge state and stays high until `sg_rdy` is sampled high.
- R7: `core_clk_en` falls (stop grant, state 6) only after `sg_rdy` has been sampled high and, when `wb_chk_en` is 1, after `wb_empty` has been sampled high at or after entry to the acknowledge state. The two may come in either order or together. If ready comes first, the machine waits in state 5.
- R8: With `wb_chk_en` at 0, `wb_empty` is ignored. Stop grant is entered the cycle after `sg_rdy` even while `wb_empty` stays 0.
- R9: Once flushing has begun, withdrawing the request does not abort the sequence. Stop grant is still reached.
- R10: Stop grant survives a stopped clock. When edges resume, the state is still 6 with `core_clk_en` at 0.
- R11: Exit from stop grant starts when the synchronized request is absent. The wake state (7) has `core_clk_en` at 1 and `resume` at 0. The next cycle is running (0) with a one-cycle `resume` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core/bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| stop_req_n | input | 1 | Active-low stop request from system logic, may be asynchronous |
| retire_bnd | input | 1 | Instruction-retirement boundary strobe |
| flush_done | input | 1 | Pipeline flush complete |
| bus_idle | input | 1 | No pending or in-progress bus cycles |
| sg_rdy | input | 1 | Bus ready for the stop-grant acknowledge cycle |
| wb_empty | input | 1 | Write buffers empty |
| wb_chk_en | input | 1 | 1: wait for `wb_empty`; 0: ignore it |
| flush_req | output | 1 | Pipeline flush request |
| sg_cyc_req | output | 1 | Stop-grant acknowledge bus cycle request |
| core_clk_en | output | 1 | Internal core clock enable |
| resume | output | 1 | One-cycle pulse after the clock is re-enabled |
| pwr_state | output | 3 | Current power state code (0 to 7 as in the requirements) |

## Verification
The bench drives the two qualifiers with ready first, write-buffer-empty first, and both in the same cycle. A design that latched only one of them would either gate the clock too early or hang in the acknowledge state. It sends a request pulse exactly two clocks wide and a request withdrawn before the boundary. A synchronizer that is too narrow would miss the pulse, and a careless boundary-wait state would raise `flush_req` it should never raise. It also withdraws the request in mid-flush and halts the clock during stop grant. A sequencer that aborted part-way, or lost its state across the halted clock, would end up in the wrong state at the next edge. A reference model compares the exact state and every output on each cycle, so a wrong synchronizer depth or a wake ordering that raised `resume` before the clock shows up at once.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  localparam int PS_W = 3;

  typedef enum logic [PS_W-1:0] {
    PS_RUN        = 3'd0,
    PS_WAIT_BND   = 3'd1,
    PS_FLUSH      = 3'd2,
    PS_DRAIN      = 3'd3,
    PS_ACK        = 3'd4,
    PS_WAIT_QUAL  = 3'd5,
    PS_STOP_GRANT = 3'd6,
    PS_WAKE       = 3'd7
  } pwr_state_e;
endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int TOP = STAGES - 1;

  logic [TOP:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[TOP-1:0], din};
  end

  assign dout = chain_q[TOP];
endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
  import pwrseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stop_rq,
  input  logic       retire_bnd,
  input  logic       flush_done,
  input  logic       bus_idle,
  input  logic       sg_rdy,
  input  logic       wb_empty,
  input  logic       wb_chk_en,
  output pwr_state_e state_o,
  output logic       flush_req,
  output logic       sg_cyc_req,
  output logic       core_clk_en,
  output logic       resume
);
  pwr_state_e state_q, state_d;
  logic       state_en;
  logic       wb_seen_q, wb_seen_d;
  logic       resume_d, resume_q;
  logic       wb_ok;

  assign wb_ok = !wb_chk_en || wb_empty || wb_seen_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      PS_RUN:        if (stop_rq) state_d = PS_WAIT_BND;
      PS_WAIT_BND: begin
        if (!stop_rq)        state_d = PS_RUN;
        else if (retire_bnd) state_d = PS_FLUSH;
      end
      PS_FLUSH:      if (flush_done) state_d = PS_DRAIN;
      PS_DRAIN:      if (bus_idle)   state_d = PS_ACK;
      PS_ACK:        if (sg_rdy)     state_d = wb_ok ? PS_STOP_GRANT : PS_WAIT_QUAL;
      PS_WAIT_QUAL:  if (wb_ok)      state_d = PS_STOP_GRANT;
      PS_STOP_GRANT: if (!stop_rq)   state_d = PS_WAKE;
      PS_WAKE:                       state_d = PS_RUN;
      default:                       state_d = PS_RUN;
    endcase
  end

  assign state_en  = (state_d != state_q);
  assign wb_seen_d = (state_q == PS_ACK) ? (wb_seen_q | (wb_chk_en & wb_empty)) : 1'b0;
  assign resume_d  = (state_q == PS_WAKE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= PS_RUN;
      wb_seen_q <= 1'b0;
      resume_q  <= 1'b0;
    end else begin
      if (state_en) state_q <= state_d;
      wb_seen_q <= wb_seen_d;
      resume_q  <= resume_d;
    end
  end

  assign state_o     = state_q;
  assign flush_req   = (state_q == PS_FLUSH);
  assign sg_cyc_req  = (state_q == PS_ACK);
  assign core_clk_en = (state_q != PS_STOP_GRANT);
  assign resume      = resume_q;

  // R4
  withdraw_no_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == PS_WAIT_BND && state_q == PS_RUN) |-> !$past(stop_rq));

  // R5
  drain_after_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_DRAIN && $past(state_q) != PS_DRAIN) |->
      ($past(state_q) == PS_FLUSH && $past(flush_done)));

  // R6
  ack_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sg_cyc_req && !sg_rdy) |=> sg_cyc_req);

  // R7
  gate_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(core_clk_en)) |->
      (($past(state_q) == PS_ACK && $past(sg_rdy)) || $past(state_q) == PS_WAIT_QUAL));

  // R8
  wb_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == PS_WAIT_QUAL && state_q == PS_STOP_GRANT) |->
      $past(wb_empty || !wb_chk_en));

  // R11
  wake_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resume) |-> (core_clk_en && $past(core_clk_en) && state_q == PS_RUN));
endmodule

// File: rtl/stopgnt_seq.sv
module stopgnt_seq
  import pwrseq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stop_req_n,
  input  logic            retire_bnd,
  input  logic            flush_done,
  input  logic            bus_idle,
  input  logic            sg_rdy,
  input  logic            wb_empty,
  input  logic            wb_chk_en,
  output logic            flush_req,
  output logic            sg_cyc_req,
  output logic            core_clk_en,
  output logic            resume,
  output logic [PS_W-1:0] pwr_state
);
  logic       rst_int_n;
  logic       req_n_sync;
  pwr_state_e state;

  pwrseq_sync #(.STAGES(RST_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (1'b1),
    .dout (rst_int_n)
  );

  pwrseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_req_sync (
    .clk  (clk),
    .rst_n(rst_int_n),
    .din  (stop_req_n),
    .dout (req_n_sync)
  );

  pwrseq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .stop_rq    (~req_n_sync),
    .retire_bnd (retire_bnd),
    .flush_done (flush_done),
    .bus_idle   (bus_idle),
    .sg_rdy     (sg_rdy),
    .wb_empty   (wb_empty),
    .wb_chk_en  (wb_chk_en),
    .state_o    (state),
    .flush_req  (flush_req),
    .sg_cyc_req (sg_cyc_req),
    .core_clk_en(core_clk_en),
    .resume     (resume)
  );

  assign pwr_state = state;

  // R10
  stop_grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($past(state) == PS_STOP_GRANT) |->
      (state == PS_STOP_GRANT || state == PS_WAKE));
endmodule

// File: tb/sim_stopgnt_seq.sv
module sim_stopgnt_seq;
  logic clk = 1'b0;
  logic clk_run = 1'b1;
  logic rst_n, stop_req_n, retire_bnd, flush_done, bus_idle, sg_rdy, wb_empty, wb_chk_en;
  logic flush_req, sg_cyc_req, core_clk_en, resume;
  logic [2:0] pwr_state;

  int checks = 0;
  int errors = 0;
  bit chk_on = 0;
  bit seen [8];
  bit seen_flush;

  // reference model state
  int m_st, rc;
  bit s1, s2, m_res, m_wbs;

  always begin
    #10;
    if (clk_run) clk = ~clk;
  end

  stopgnt_seq u0 (
    .clk(clk), .rst_n(rst_n), .stop_req_n(stop_req_n), .retire_bnd(retire_bnd),
    .flush_done(flush_done), .bus_idle(bus_idle), .sg_rdy(sg_rdy), .wb_empty(wb_empty),
    .wb_chk_en(wb_chk_en), .flush_req(flush_req), .sg_cyc_req(sg_cyc_req),
    .core_clk_en(core_clk_en), .resume(resume), .pwr_state(pwr_state)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model: advanced on each rising edge
  always @(posedge clk) begin
    int nxt;
    bit rq, wok;
    if (!rst_n) begin
      m_st = 0; rc = 0; s1 = 1; s2 = 1; m_res = 0; m_wbs = 0;
    end else if (rc < 2) begin
      rc++;
    end else begin
      rq  = !s2;
      wok = !wb_chk_en || wb_empty || m_wbs;
      nxt = m_st;
      case (m_st)
        0: if (rq) nxt = 1;
        1: nxt = !rq ? 0 : (retire_bnd ? 2 : 1);
        2: if (flush_done) nxt = 3;
        3: if (bus_idle) nxt = 4;
        4: if (sg_rdy) nxt = wok ? 6 : 5;
        5: if (wok) nxt = 6;
        6: if (!rq) nxt = 7;
        default: nxt = 0;
      endcase
      m_res = (m_st == 7);
      m_wbs = (m_st == 4) ? (m_wbs || (wb_chk_en && wb_empty)) : 1'b0;
      m_st  = nxt;
      s2 = s1;
      s1 = stop_req_n;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && chk_on) begin
      check("R3 state", pwr_state, m_st);
      check("R7 core_clk_en", core_clk_en, m_st != 6);
      check("R5 flush_req", flush_req, m_st == 2);
      check("R6 sg_cyc_req", sg_cyc_req, m_st == 4);
      check("R11 resume", resume, m_res);
    end
    seen[pwr_state] = 1'b1;
    if (flush_req) seen_flush = 1'b1;
  end

  task automatic clear_seen();
    for (int i = 0; i < 8; i++) seen[i] = 1'b0;
    seen_flush = 1'b0;
  endtask

  task automatic wait_state(input int s, input int max, input string tag);
    bit hit = 0;
    for (int i = 0; i < max && !hit; i++) begin
      @(negedge clk);
      if (pwr_state == 3'(s)) hit = 1;
    end
    check(tag, pwr_state, s);
  endtask

  task automatic to_flush();
    stop_req_n = 1'b0;
    wait_state(1, 6, "R2 enter boundary wait");
    repeat (3) @(negedge clk);
    check("R3 holds without boundary", pwr_state, 1);
    retire_bnd = 1'b1;
    @(negedge clk);
    retire_bnd = 1'b0;
    check("R3 flush after boundary", pwr_state, 2);
  endtask

  task automatic to_ack();
    repeat (2) @(negedge clk);
    flush_done = 1'b1;
    @(negedge clk);
    flush_done = 1'b0;
    check("R5 drain after flush", pwr_state, 3);
    repeat (2) @(negedge clk);
    bus_idle = 1'b1;
    @(negedge clk);
    bus_idle = 1'b0;
    check("R5 ack after drain", pwr_state, 4);
  endtask

  task automatic qual(input int rdy_t, input int wb_t, input bit wb_en);
    clear_seen();
    wb_chk_en = wb_en;
    check("R6 ack request raised", sg_cyc_req, 1);
    for (int t = 0; t < 8; t++) begin
      sg_rdy   = (t == rdy_t);
      wb_empty = (t == wb_t);
      @(negedge clk);
    end
    sg_rdy = 1'b0;
    wb_empty = 1'b0;
    check("R7 stop grant reached", seen[6], 1);
  endtask

  task automatic leave();
    stop_req_n = 1'b1;
    wait_state(7, 6, "R11 wake state");
    check("R11 clock on in wake", core_clk_en, 1);
    check("R11 no resume in wake", resume, 0);
    @(negedge clk);
    check("R11 running after wake", pwr_state, 0);
    check("R11 resume pulse", resume, 1);
    @(negedge clk);
    check("R11 resume one cycle", resume, 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; stop_req_n = 1'b1; retire_bnd = 1'b0; flush_done = 1'b0;
    bus_idle = 1'b0; sg_rdy = 1'b0; wb_empty = 1'b0; wb_chk_en = 1'b1;
    m_st = 0; rc = 0; s1 = 1; s2 = 1; m_res = 0; m_wbs = 0;
    clear_seen();
    repeat (3) @(negedge clk);
    check("R1 reset state", pwr_state, 0);
    check("R1 reset clock enable", core_clk_en, 1);
    check("R1 reset flush_req", flush_req, 0);
    check("R1 reset sg_cyc_req", sg_cyc_req, 0);
    check("R1 reset resume", resume, 0);
    rst_n = 1'b1;
    chk_on = 1'b1;
    repeat (4) @(negedge clk);

    // ready before write-buffer empty
    to_flush(); to_ack(); qual(1, 4, 1'b1);
    check("R7 gated after both", core_clk_en, 0);
    leave();
    // write-buffer empty before ready
    to_flush(); to_ack(); qual(4, 1, 1'b1);
    check("R7 wb first gated", pwr_state, 6);
    leave();
    // both in the same cycle
    to_flush(); to_ack(); qual(2, 2, 1'b1);
    check("R7 same cycle gated", pwr_state, 6);
    leave();
    // qualifier masked: wb_empty never asserted
    to_flush(); to_ack(); qual(0, 99, 1'b0);
    check("R8 masked wb ignored", pwr_state, 6);
    check("R8 never waited", seen[5], 0);
    leave();
    wb_chk_en = 1'b1;

    // withdrawn before a boundary
    clear_seen();
    stop_req_n = 1'b0;
    wait_state(1, 6, "R4 boundary wait");
    @(negedge clk);
    stop_req_n = 1'b1;
    wait_state(0, 6, "R4 back to running");
    repeat (2) @(negedge clk);
    check("R4 no flush requested", seen_flush, 0);

    // two-clock request pulse
    clear_seen();
    stop_req_n = 1'b0;
    repeat (2) @(negedge clk);
    stop_req_n = 1'b1;
    repeat (8) @(negedge clk);
    check("R2 pulse caught", seen[1], 1);
    check("R2 back to running", pwr_state, 0);

    // request dropped during flush
    to_flush();
    stop_req_n = 1'b1;
    to_ack(); qual(0, 0, 1'b1);
    wait_state(0, 6, "R9 returned to running");
    check("R9 wake passed", seen[7], 1);

    // clock halted in stop grant
    to_flush(); to_ack(); qual(1, 1, 1'b1);
    clk_run = 1'b0;
    #1000;
    clk_run = 1'b1;
    @(negedge clk);
    check("R10 state after restart", pwr_state, 6);
    check("R10 clock still gated", core_clk_en, 0);
    leave();

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule